// File: doc/BRIEF.md
# Relative Branch Condition Unit

This unit decides the relative branches of an 8-bit microcontroller core. For each branch operation it is handed, it reports three things: whether the branch is taken, the program counter that execution continues from, and the number of machine cycles the instruction costs. The core supplies the current flag byte, a byte to test with a bit index, the address of the instruction after the branch, and a signed 8-bit displacement.

Branches come in four groups:

- flag-condition branches on C, Z, N or V;
- an unconditional branch;
- bit-test branches on the accumulator;
- bit-test branches on a direct-page byte that the core has already read.

Each group has its own cost when taken and when not taken, and the unit reports that cost so the sequencer can schedule the next fetch.

The unit evaluates one operation per cycle and has one register stage. An operation sampled with `valid_i` high appears on the outputs after the next rising clock edge, together with `valid_o`. The unit never writes the flags; branches leave them untouched.

Top module: `rbu_top`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted operation, `valid_o`, `taken_o`, `target_o` and `cycles_o` are all zero.
- R2: An operation sampled on a rising edge with `valid_i`=1 appears on the outputs after that edge, with `valid_o`=1. When `valid_i`=0, `valid_o` goes to 0 and `taken_o`, `target_o` and `cycles_o` keep their last values.
- R3: The flag byte `flags_i` holds N at bit 7, V at bit 6, Z at bit 1 and C at bit 0. The flag branch codes on `op_i` are:
  - 1 taken when C=0, 2 taken when C=1;
  - 3 taken when Z=1, 4 taken when Z=0;
  - 5 taken when N=1, 6 taken when N=0;
  - 7 taken when V=0, 8 taken when V=1.
- R4: Code 0 is always taken, whatever the flags are.
- R5: The bit-test codes test bit `bit_sel_i` of `data_i`. Code 9 (accumulator) and code 11 (direct-page byte) are taken when that bit is 0. Code 10 (accumulator) and code 12 (direct-page byte) are taken when that bit is 1.
- R6: When a branch is taken, `target_o` = `next_pc_i` + sign-extended `disp_i`, modulo 2^16. This covers displacements of -128 and +127 and wrap across 0x0000/0xFFFF.
- R7: When a branch is not taken, `target_o` equals `next_pc_i`.
- R8: `cycles_o` reports the cost as follows:

  | Group | Not taken | Taken |
  |---|---|---|
  | Flag branch | 2 | 4 |
  | Unconditional | — | 4 |
  | Accumulator bit test | 4 | 6 |
  | Direct-page bit test | 5 | 7 |

- R9: Codes 13 to 15 are not branches: `taken_o`=0, `target_o`=`next_pc_i` and `cycles_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Branch operation code |
| flags_i | input | 8 | Flag byte (N=7, V=6, Z=1, C=0) |
| data_i | input | 8 | Byte tested by bit branches (accumulator or direct-page operand) |
| bit_sel_i | input | 3 | Bit index for bit branches |
| next_pc_i | input | 16 | Address of the instruction after the branch |
| disp_i | input | 8 | Signed relative displacement |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |
| cycles_o | output | 4 | Instruction cycle cost |

## Verification
The hardest cases to reach are the target adder's carry and borrow out of bit 15. These need a next-instruction address near 0x0000 or 0xFFFF, an extreme displacement, and a condition that actually holds, all at the same time. The stimulus pins the addresses at those edges and uses the always-taken code and true flag conditions with displacements of -128, -1, +1 and +127. A sweep of all 256 flag bytes through every flag code exposes any condition that reads the wrong bit. Walking single-bit and single-zero bytes through all eight bit indices does the same for the bit-test branches.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  typedef enum logic [3:0] {
    OP_ALWAYS      = 4'd0,
    OP_C_CLR       = 4'd1,
    OP_C_SET       = 4'd2,
    OP_Z_SET       = 4'd3,
    OP_Z_CLR       = 4'd4,
    OP_N_SET       = 4'd5,
    OP_N_CLR       = 4'd6,
    OP_V_CLR       = 4'd7,
    OP_V_SET       = 4'd8,
    OP_ACC_BIT_CLR = 4'd9,
    OP_ACC_BIT_SET = 4'd10,
    OP_MEM_BIT_CLR = 4'd11,
    OP_MEM_BIT_SET = 4'd12
  } br_op_e;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_ALWAYS = 3'd1,
    CLS_FLAG   = 3'd2,
    CLS_ACC    = 3'd3,
    CLS_MEM    = 3'd4
  } br_cls_e;

  localparam logic [2:0] FLG_N = 3'd7;
  localparam logic [2:0] FLG_V = 3'd6;
  localparam logic [2:0] FLG_Z = 3'd1;
  localparam logic [2:0] FLG_C = 3'd0;

  typedef struct packed {
    br_cls_e    cls;
    logic       want_set;
    logic [2:0] flag_idx;
  } br_dec_t;
endpackage

// File: rtl/rbu_decode.sv
module rbu_decode
  import rbu_pkg::*;
(
  input  logic [3:0] op_i,
  output br_dec_t    dec_o
);
  always_comb begin
    dec_o = '{cls: CLS_NONE, want_set: 1'b0, flag_idx: FLG_C};
    case (op_i)
      OP_ALWAYS:      dec_o.cls = CLS_ALWAYS;
      OP_C_CLR:       dec_o = '{CLS_FLAG, 1'b0, FLG_C};
      OP_C_SET:       dec_o = '{CLS_FLAG, 1'b1, FLG_C};
      OP_Z_SET:       dec_o = '{CLS_FLAG, 1'b1, FLG_Z};
      OP_Z_CLR:       dec_o = '{CLS_FLAG, 1'b0, FLG_Z};
      OP_N_SET:       dec_o = '{CLS_FLAG, 1'b1, FLG_N};
      OP_N_CLR:       dec_o = '{CLS_FLAG, 1'b0, FLG_N};
      OP_V_CLR:       dec_o = '{CLS_FLAG, 1'b0, FLG_V};
      OP_V_SET:       dec_o = '{CLS_FLAG, 1'b1, FLG_V};
      OP_ACC_BIT_CLR: dec_o = '{CLS_ACC, 1'b0, FLG_C};
      OP_ACC_BIT_SET: dec_o = '{CLS_ACC, 1'b1, FLG_C};
      OP_MEM_BIT_CLR: dec_o = '{CLS_MEM, 1'b0, FLG_C};
      OP_MEM_BIT_SET: dec_o = '{CLS_MEM, 1'b1, FLG_C};
      default:        dec_o.cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/rbu_cond.sv
module rbu_cond
  import rbu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  br_dec_t           dec_i,
  input  logic [7:0]        flags_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  output logic              taken_o
);
  logic tested;

  always_comb begin
    unique case (dec_i.cls)
      CLS_FLAG:         tested = flags_i[dec_i.flag_idx];
      CLS_ACC, CLS_MEM: tested = data_i[bit_sel_i];
      default:          tested = 1'b0;
    endcase
  end

  always_comb begin
    case (dec_i.cls)
      CLS_ALWAYS:                 taken_o = 1'b1;
      CLS_FLAG, CLS_ACC, CLS_MEM: taken_o = (tested == dec_i.want_set);
      default:                    taken_o = 1'b0;
    endcase
  end

  // R9: non-branch codes never take
  always_comb begin
    if (dec_i.cls == CLS_NONE) a_r9_none_not_taken: assert (!taken_o);
  end
endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              taken_i,
  output logic [PC_W-1:0]   target_o
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] sum;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign sum      = next_pc_i + disp_ext;
  assign target_o = taken_i ? sum : next_pc_i;
endmodule

// File: rtl/rbu_cost.sv
module rbu_cost
  import rbu_pkg::*;
#(
  parameter int CYC_W       = 4,
  parameter int FLAG_NT     = 2,
  parameter int FLAG_TK     = 4,
  parameter int ALWAYS_TK   = 4,
  parameter int ACC_NT      = 4,
  parameter int ACC_TK      = 6,
  parameter int MEM_NT      = 5,
  parameter int MEM_TK      = 7
) (
  input  br_cls_e          cls_i,
  input  logic             taken_i,
  output logic [CYC_W-1:0] cycles_o
);
  always_comb begin
    case (cls_i)
      CLS_ALWAYS: cycles_o = CYC_W'(ALWAYS_TK);
      CLS_FLAG:   cycles_o = taken_i ? CYC_W'(FLAG_TK) : CYC_W'(FLAG_NT);
      CLS_ACC:    cycles_o = taken_i ? CYC_W'(ACC_TK)  : CYC_W'(ACC_NT);
      CLS_MEM:    cycles_o = taken_i ? CYC_W'(MEM_TK)  : CYC_W'(MEM_NT);
      default:    cycles_o = '0;
    endcase
  end
endmodule

// File: rtl/rbu_top.sv
module rbu_top
  import rbu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 4,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [7:0]        flags_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o,
  output logic [CYC_W-1:0]  cycles_o
);
  br_dec_t          dec;
  logic             taken_c;
  logic [PC_W-1:0]  target_c;
  logic [CYC_W-1:0] cycles_c;

  rbu_decode u_dec (.op_i(op_i), .dec_o(dec));

  rbu_cond #(.DATA_W(DATA_W)) u_cond (
    .dec_i(dec), .flags_i(flags_i), .data_i(data_i),
    .bit_sel_i(bit_sel_i), .taken_o(taken_c)
  );

  rbu_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .next_pc_i(next_pc_i), .disp_i(disp_i), .taken_i(taken_c),
    .target_o(target_c)
  );

  rbu_cost #(.CYC_W(CYC_W)) u_cost (
    .cls_i(dec.cls), .taken_i(taken_c), .cycles_o(cycles_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      target_o <= '0;
      cycles_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o  <= taken_c;
        target_o <= target_c;
        cycles_o <= cycles_c;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(target_o) && $stable(taken_o) && $stable(cycles_o)));
  a_r7_not_taken_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !taken_c) |=> (target_o == $past(next_pc_i)));
  a_r4_always_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0) |=> (taken_o && cycles_o == CYC_W'(4)));
  a_r8_taken_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> (cycles_o >= CYC_W'(4)));
endmodule

// File: tb/tb_rbu_top.sv
module tb_rbu_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  flags_i = '0;
  logic [7:0]  data_i = '0;
  logic [2:0]  bit_sel_i = '0;
  logic [15:0] next_pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic        valid_o, taken_o;
  logic [15:0] target_o;
  logic [3:0]  cycles_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic        taken;
    logic [15:0] target;
    logic [3:0]  cycles;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  rbu_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .flags_i(flags_i), .data_i(data_i), .bit_sel_i(bit_sel_i),
    .next_pc_i(next_pc_i), .disp_i(disp_i), .valid_o(valid_o),
    .taken_o(taken_o), .target_o(target_o), .cycles_o(cycles_o)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // reference model from requirements R3..R9
  function automatic exp_t model(input logic [3:0] op, input logic [7:0] f,
                                 input logic [7:0] d, input logic [2:0] b,
                                 input logic [15:0] pc, input logic [7:0] ds);
    exp_t e;
    logic t;
    logic [3:0] nt, tk;
    logic [15:0] sext;
    sext = {{8{ds[7]}}, ds};
    e.tag = "R3";
    case (op)
      4'd0: begin t = 1; nt = 4; tk = 4; e.tag = "R4"; end
      4'd1: begin t = !f[0]; nt = 2; tk = 4; end
      4'd2: begin t = f[0];  nt = 2; tk = 4; end
      4'd3: begin t = f[1];  nt = 2; tk = 4; end
      4'd4: begin t = !f[1]; nt = 2; tk = 4; end
      4'd5: begin t = f[7];  nt = 2; tk = 4; end
      4'd6: begin t = !f[7]; nt = 2; tk = 4; end
      4'd7: begin t = !f[6]; nt = 2; tk = 4; end
      4'd8: begin t = f[6];  nt = 2; tk = 4; end
      4'd9:  begin t = !d[b]; nt = 4; tk = 6; e.tag = "R5"; end
      4'd10: begin t = d[b];  nt = 4; tk = 6; e.tag = "R5"; end
      4'd11: begin t = !d[b]; nt = 5; tk = 7; e.tag = "R5"; end
      4'd12: begin t = d[b];  nt = 5; tk = 7; e.tag = "R5"; end
      default: begin t = 0; nt = 0; tk = 0; e.tag = "R9"; end
    endcase
    e.taken  = t;
    e.target = t ? pc + sext : pc;
    e.cycles = t ? tk : nt;
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] f,
                       input logic [7:0] d, input logic [2:0] b,
                       input logic [15:0] pc, input logic [7:0] ds);
    @(negedge clk);
    op_i = op; flags_i = f; data_i = d; bit_sel_i = b;
    next_pc_i = pc; disp_i = ds; valid_i = 1'b1;
    sb.push_back(model(op, f, d, b, pc, ds));
  endtask

  // monitor: R6 target, R7 not-taken target, R8 cost plus condition tag
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        check(0, "R2", "valid_o without pending item (act valid_o=1 exp 0)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(taken_o == e.taken, e.tag,
              $sformatf("taken act=%0b exp=%0b", taken_o, e.taken));
        check(target_o == e.target, e.taken ? "R6" : "R7",
              $sformatf("target act=%h exp=%h", target_o, e.target));
        check(cycles_o == e.cycles, "R8",
              $sformatf("cycles act=%0d exp=%0d", cycles_o, e.cycles));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (act=timeout exp=finish)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic        h_taken;
    logic [15:0] h_target;
    logic [3:0]  h_cycles;
    repeat (3) @(negedge clk);
    check({valid_o, taken_o, target_o, cycles_o} == '0, "R1",
          $sformatf("reset outputs act=%0b/%0b/%h/%0d exp 0", valid_o, taken_o, target_o, cycles_o));
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    check({valid_o, taken_o, target_o, cycles_o} == '0, "R1",
          $sformatf("idle after reset act=%0b/%0b/%h/%0d exp 0", valid_o, taken_o, target_o, cycles_o));

    // R3: every flag code against every flag byte
    for (int op = 1; op <= 8; op++)
      for (int f = 0; f < 256; f++)
        drive(op[3:0], f[7:0], 8'h00, 3'd0, 16'h1234 + 16'(f), 8'(f * 7));

    // R4: always taken regardless of flags
    for (int f = 0; f < 256; f += 17) drive(4'd0, f[7:0], 8'h00, 3'd0, 16'h4000, 8'h10);

    // R5: walking one / walking zero across all bit indices
    for (int op = 9; op <= 12; op++)
      for (int b = 0; b < 8; b++) begin
        drive(op[3:0], 8'h00, 8'(1 << b), b[2:0], 16'h2000, 8'h05);
        drive(op[3:0], 8'hFF, ~8'(1 << b), b[2:0], 16'h2000, 8'hFB);
        drive(op[3:0], 8'h00, 8'hA5, b[2:0], 16'h8000, 8'h7F);
      end

    // R6: extreme displacements and wraparound
    drive(4'd0, 8'h00, 8'h00, 3'd0, 16'h0000, 8'hFF);
    drive(4'd0, 8'h00, 8'h00, 3'd0, 16'h0000, 8'h80);
    drive(4'd0, 8'h00, 8'h00, 3'd0, 16'hFFFF, 8'h01);
    drive(4'd0, 8'h00, 8'h00, 3'd0, 16'hFFFF, 8'h7F);
    drive(4'd1, 8'h00, 8'h00, 3'd0, 16'hFF90, 8'h7F);
    drive(4'd3, 8'h02, 8'h00, 3'd0, 16'h0010, 8'h80);
    drive(4'd10, 8'h00, 8'h80, 3'd7, 16'hFFFE, 8'h7F);
    drive(4'd11, 8'h00, 8'h00, 3'd3, 16'h0001, 8'h80);

    // R7: not taken at the address edges
    drive(4'd2, 8'h00, 8'h00, 3'd0, 16'hFFFF, 8'h7F);
    drive(4'd4, 8'h02, 8'h00, 3'd0, 16'h0000, 8'h80);

    // R9: non-branch codes
    for (int op = 13; op <= 15; op++) drive(op[3:0], 8'hFF, 8'hFF, 3'd2, 16'hBEEF, 8'h80);

    // R2: hold while valid_i low
    drive(4'd0, 8'h00, 8'h00, 3'd0, 16'h1000, 8'h20);
    @(negedge clk) valid_i = 1'b0;
    h_taken = taken_o; h_target = target_o; h_cycles = cycles_o;
    op_i = 4'd12; data_i = 8'h00; next_pc_i = 16'h5555; disp_i = 8'h33;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R2", $sformatf("valid_o idle act=%0b exp=0", valid_o));
    check({taken_o, target_o, cycles_o} == {h_taken, h_target, h_cycles}, "R2",
          $sformatf("hold act=%0b/%h/%0d exp=%0b/%h/%0d", taken_o, target_o, cycles_o,
                    h_taken, h_target, h_cycles));
    check(sb.size() == 0, "R2", $sformatf("pending items act=%0d exp=0", sb.size()));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule